// File: doc/BRIEF.md
# Configurable Multiply-Add Arithmetic Slice

This block is an arithmetic slice with four multipliers. Each multiplier takes two operands of `OPW` bits, 18 by default. A multiplier can also be split into two half-width multipliers, so the slice can produce four large products or eight small ones. After the multipliers come a pair adder/subtractor, a four-product summation and a wide accumulator. A lane multiplexer, controlled by a static mode input, selects which of these stages drives the four result lanes. The slice runs in exactly one mode at a time, and all four multipliers serve that mode.

Each result lane passes through an output stage that is either bypassed (combinational) or registered. A registered lane has its own clock enable and its own asynchronous clear, so the four lanes can be pipelined and cleared independently. Each operand of each multiplier is signed or unsigned according to its own sign control. Every product is exact, and it is sign- or zero-extended before it is added or placed on a lane.

Top module: `dsp_slice`

## Requirements
- R1: With `cfg_mode`=0 (plain multiply) and `cfg_split`=0, lane i (`res_o[i*52 +: 52]`) carries the exact product `a_i[i*18 +: 18]` × `b_i[i*18 +: 18]`, sign-extended to 52 bits. Operand A of multiplier i is signed when `a_sgn[i]`=1 and unsigned when it is 0; `b_sgn[i]` does the same for operand B.
- R2: With `cfg_mode`=0 and `cfg_split`=1, lane bits [17:0] hold the product of the low 9 bits of each operand and bits [35:18] hold the product of the high 9 bits, each kept to 18 bits. The signedness of both halves follows `a_sgn[i]`/`b_sgn[i]`, and lane bits [51:36] are zero.
- R3: With `cfg_mode`=1 (multiply-accumulate), every clock edge adds product 0 to a 52-bit two's-complement accumulator, or subtracts it when `acc_sub`=1. Lane 0 shows the accumulator and lanes 1 to 3 are zero.
- R4: In accumulate mode, an edge with `acc_clr`=1 loads the accumulator with product 0 alone, whatever `acc_sub` is. While the mode is not 1, the accumulator is held at zero.
- R5: With `cfg_mode`=2 (pair sum), lane 0 = p0+p1, or p0−p1 when `pair_sub[0]`=1. Lane 1 = p2+p3, or p2−p3 when `pair_sub[1]`=1. Both are sign-extended, and lanes 2 and 3 are zero.
- R6: With `cfg_mode`=3 (four-product sum), lane 0 = (p0±p1)+(p2±p3), with the pair signs chosen as in R5. Lanes 1 to 3 are zero.
- R7: `cfg_split` has no effect in modes 1, 2 and 3.
- R8: With `cfg_reg_en[g]`=0, lane g follows its selected value combinationally, in the same cycle.
- R9: With `cfg_reg_en[g]`=1, lane g takes its selected value at a clock edge where `grp_ce[g]`=1 and holds it at every other edge. A low `rst_n` at an edge zeroes all lane registers.
- R10: A high `grp_clr[g]` forces lane register g to zero at once, without a clock edge, and leaves the other lanes untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | 0 multiply, 1 accumulate, 2 pair sum, 3 four-product sum |
| cfg_split | input | 1 | Split each multiplier into two half-width multipliers (multiply mode only) |
| cfg_reg_en | input | 4 | Per-lane select: 1 registered, 0 bypassed |
| a_i | input | 72 | Four A operands, multiplier i at bits [i*18 +: 18] |
| b_i | input | 72 | Four B operands, multiplier i at bits [i*18 +: 18] |
| a_sgn | input | 4 | Per-multiplier signedness of operand A |
| b_sgn | input | 4 | Per-multiplier signedness of operand B |
| pair_sub | input | 2 | Subtract the second product of pair 0 / pair 1 |
| acc_sub | input | 1 | Accumulator subtracts this cycle |
| acc_clr | input | 1 | Accumulator loads product 0 this cycle |
| grp_ce | input | 4 | Per-lane register clock enable |
| grp_clr | input | 4 | Per-lane register asynchronous clear, active high |
| res_o | output | 208 | Four 52-bit result lanes, lane g at bits [g*52 +: 52] |

## Verification
The properties assume that `grp_clr` changes only away from the rising edge and that, once raised, it stays high across at least one rising edge. The bench meets this by driving every control on the falling edge. The lane-zero properties apply only while the lanes concerned are bypassed, so they assume the register enables are set before results are compared. The bench always sets the mode, split and register enables together with, or ahead of, the operands they govern. The mode is changed only between scenarios, and each scenario starts from a freshly zeroed accumulator.

// File: rtl/dsp_slice_pkg.sv
// Package: shared mode encoding and lane count for the arithmetic slice.
// Assumes the slice always has four multipliers and four result lanes.
package dsp_slice_pkg;
    localparam int NLANE = 4;

    typedef enum logic [1:0] {
        MODE_MUL  = 2'd0,
        MODE_MAC  = 2'd1,
        MODE_ADD2 = 2'd2,
        MODE_ADD4 = 2'd3
    } mode_e;
endpackage

// File: rtl/dsp_mult.sv
// Module: one multiplier with selectable operand signedness. It gives the
// exact full-width product and, in parallel, two half-width products packed
// {hi, lo}. Assumes OPW is even.
module dsp_mult #(
    parameter int OPW = 18
) (
    input  logic [OPW-1:0]          a,
    input  logic [OPW-1:0]          b,
    input  logic                    a_sgn,
    input  logic                    b_sgn,
    output logic signed [2*OPW+1:0] prod_full,
    output logic [2*OPW-1:0]        prod_split
);
    localparam int PW = 2*OPW + 2;
    localparam int HW = OPW / 2;
    localparam int SW = 2 * HW;

    logic signed [PW-1:0] ax, bx;
    logic signed [SW-1:0] lo_a, lo_b, hi_a, hi_b;
    logic [SW-1:0] lo_p, hi_p;

    // Extend operands to the product width so the multiply is exact.
    always_comb begin
        ax   = {{(OPW+2){a_sgn & a[OPW-1]}}, a};
        bx   = {{(OPW+2){b_sgn & b[OPW-1]}}, b};
        lo_a = {{HW{a_sgn & a[HW-1]}}, a[HW-1:0]};
        lo_b = {{HW{b_sgn & b[HW-1]}}, b[HW-1:0]};
        hi_a = {{HW{a_sgn & a[OPW-1]}}, a[OPW-1:HW]};
        hi_b = {{HW{b_sgn & b[OPW-1]}}, b[OPW-1:HW]};
    end

    // Form the full product and the two half products.
    always_comb begin
        prod_full  = ax * bx;
        lo_p       = lo_a * lo_b;
        hi_p       = hi_a * hi_b;
        prod_split = {hi_p, lo_p};
    end
endmodule

// File: rtl/dsp_sum.sv
// Module: pair adder/subtractor and four-product summation. Assumes signed
// product inputs; the widths grow by one bit per stage, so no result wraps.
module dsp_sum #(
    parameter int PW = 38
) (
    input  logic signed [PW-1:0] p0,
    input  logic signed [PW-1:0] p1,
    input  logic signed [PW-1:0] p2,
    input  logic signed [PW-1:0] p3,
    input  logic [1:0]           sub,
    output logic signed [PW:0]   pair0,
    output logic signed [PW:0]   pair1,
    output logic signed [PW+1:0] quad
);
    logic signed [PW:0] e0, e1, e2, e3;

    // Sign-extend the products, then combine each pair and the two pairs.
    always_comb begin
        e0    = {p0[PW-1], p0};
        e1    = {p1[PW-1], p1};
        e2    = {p2[PW-1], p2};
        e3    = {p3[PW-1], p3};
        pair0 = sub[0] ? (e0 - e1) : (e0 + e1);
        pair1 = sub[1] ? (e2 - e3) : (e2 + e3);
        quad  = {pair0[PW], pair0} + {pair1[PW], pair1};
    end
endmodule

// File: rtl/dsp_accum.sv
// Module: wide accumulator for multiply-accumulate. Assumes run stays high
// throughout a MAC session; the register is held at zero while run is low.
module dsp_accum #(
    parameter int PW = 38,
    parameter int AW = 52
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 load,
    input  logic                 sub,
    input  logic signed [PW-1:0] prod,
    output logic signed [AW-1:0] acc
);
    logic signed [AW-1:0] ext;

    // Sign-extend the incoming product to accumulator width.
    always_comb ext = {{(AW-PW){prod[PW-1]}}, prod};

    // Accumulate, reload or hold at zero at every edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) acc <= '0;
        else if (load)      acc <= ext;
        else if (sub)       acc <= acc - ext;
        else                acc <= acc + ext;
    end
endmodule

// File: rtl/dsp_outreg.sv
// Module: one output lane stage that is either bypassed or registered, the
// register having a clock enable, an asynchronous clear and a synchronous reset.
module dsp_outreg #(
    parameter int W = 52
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         aclr,
    input  logic         ce,
    input  logic         use_reg,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] q_r;

    // Lane register: the clear acts at once; reset and enable act at the edge.
    always_ff @(posedge clk or posedge aclr) begin
        if (aclr)        q_r <= '0;
        else if (!rst_n) q_r <= '0;
        else if (ce)     q_r <= d;
    end

    // Choose the registered or the combinational value.
    always_comb q = use_reg ? q_r : d;
endmodule

// File: rtl/dsp_slice.sv
// Module: top of the arithmetic slice. Four multipliers feed a pair sum, a
// four-product sum and an accumulator; a mode multiplexer drives four lanes,
// each through its own optional register. Assumes cfg_mode is static while
// results are used.
module dsp_slice
    import dsp_slice_pkg::*;
#(
    parameter int OPW   = 18,
    parameter int GUARD = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    cfg_mode,
    input  logic                          cfg_split,
    input  logic [NLANE-1:0]              cfg_reg_en,
    input  logic [NLANE*OPW-1:0]          a_i,
    input  logic [NLANE*OPW-1:0]          b_i,
    input  logic [NLANE-1:0]              a_sgn,
    input  logic [NLANE-1:0]              b_sgn,
    input  logic [1:0]                    pair_sub,
    input  logic                          acc_sub,
    input  logic                          acc_clr,
    input  logic [NLANE-1:0]              grp_ce,
    input  logic [NLANE-1:0]              grp_clr,
    output logic [NLANE*(2*OPW+GUARD)-1:0] res_o
);
    localparam int PW = 2*OPW + 2;
    localparam int SW = 2*OPW;
    localparam int LW = 2*OPW + GUARD;

    mode_e mode;
    logic signed [PW-1:0] pfull  [NLANE];
    logic [SW-1:0]        psplit [NLANE];
    logic signed [PW:0]   pair0, pair1;
    logic signed [PW+1:0] quad;
    logic signed [LW-1:0] acc;
    logic [LW-1:0]        lane   [NLANE];

    // Decode the mode input.
    always_comb mode = mode_e'(cfg_mode);

    for (genvar i = 0; i < NLANE; i++) begin : g_mul
        dsp_mult #(.OPW(OPW)) u_mult (
            .a          (a_i[i*OPW +: OPW]),
            .b          (b_i[i*OPW +: OPW]),
            .a_sgn      (a_sgn[i]),
            .b_sgn      (b_sgn[i]),
            .prod_full  (pfull[i]),
            .prod_split (psplit[i])
        );
    end

    dsp_sum #(.PW(PW)) u_sum (
        .p0    (pfull[0]),
        .p1    (pfull[1]),
        .p2    (pfull[2]),
        .p3    (pfull[3]),
        .sub   (pair_sub),
        .pair0 (pair0),
        .pair1 (pair1),
        .quad  (quad)
    );

    dsp_accum #(.PW(PW), .AW(LW)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (mode == MODE_MAC),
        .load  (acc_clr),
        .sub   (acc_sub),
        .prod  (pfull[0]),
        .acc   (acc)
    );

    // Lane multiplexer: pick the stage that drives each lane in this mode.
    always_comb begin
        for (int i = 0; i < NLANE; i++) lane[i] = '0;
        case (mode)
            MODE_MUL: begin
                for (int i = 0; i < NLANE; i++)
                    lane[i] = cfg_split ? LW'(psplit[i])
                                        : {{(LW-PW){pfull[i][PW-1]}}, pfull[i]};
            end
            MODE_MAC:  lane[0] = acc;
            MODE_ADD2: begin
                lane[0] = {{(LW-PW-1){pair0[PW]}}, pair0};
                lane[1] = {{(LW-PW-1){pair1[PW]}}, pair1};
            end
            MODE_ADD4: lane[0] = {{(LW-PW-2){quad[PW+1]}}, quad};
            default: ;
        endcase
    end

    for (genvar g = 0; g < NLANE; g++) begin : g_out
        dsp_outreg #(.W(LW)) u_oreg (
            .clk     (clk),
            .rst_n   (rst_n),
            .aclr    (grp_clr[g]),
            .ce      (grp_ce[g]),
            .use_reg (cfg_reg_en[g]),
            .d       (lane[g]),
            .q       (res_o[g*LW +: LW])
        );
    end
endmodule

// File: rtl/dsp_slice_chk.sv
// Module: property checker for dsp_slice, attached with bind below. Assumes
// grp_clr is driven away from the rising edge.
module dsp_slice_chk
    import dsp_slice_pkg::*;
#(
    parameter int OPW   = 18,
    parameter int GUARD = 16
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [1:0]                      cfg_mode,
    input logic                            cfg_split,
    input logic [NLANE-1:0]                cfg_reg_en,
    input logic [NLANE-1:0]                grp_ce,
    input logic [NLANE-1:0]                grp_clr,
    input logic [NLANE*(2*OPW+GUARD)-1:0]  res_o
);
    localparam int LW = 2*OPW + GUARD;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        // R10: a cleared lane register reads zero
        p_clr_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (grp_clr[g] && cfg_reg_en[g]) |-> (res_o[g*LW +: LW] == '0));

        // R9: a registered lane without enable keeps its value
        p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_reg_en[g] && !grp_ce[g] && !grp_clr[g]) |=>
            (grp_clr[g] || !cfg_reg_en[g] || $stable(res_o[g*LW +: LW])));

        // R2: split products leave the guard bits of each lane clear
        p_split_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_mode == MODE_MUL && cfg_split && !cfg_reg_en[g]) |->
            (res_o[g*LW+2*OPW +: GUARD] == '0));
    end

    // R3: accumulate mode drives only lane 0
    p_mac_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == MODE_MAC && cfg_reg_en[3:1] == 3'b000) |->
        (res_o[NLANE*LW-1:LW] == '0));

    // R5: pair sum mode leaves lanes 2 and 3 zero
    p_add2_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == MODE_ADD2 && cfg_reg_en[3:2] == 2'b00) |->
        (res_o[NLANE*LW-1:2*LW] == '0));

    // R6: four-product sum drives only lane 0
    p_add4_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == MODE_ADD4 && cfg_reg_en[3:1] == 3'b000) |->
        (res_o[NLANE*LW-1:LW] == '0));
endmodule

bind dsp_slice dsp_slice_chk #(.OPW(OPW), .GUARD(GUARD)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_mode   (cfg_mode),
    .cfg_split  (cfg_split),
    .cfg_reg_en (cfg_reg_en),
    .grp_ce     (grp_ce),
    .grp_clr    (grp_clr),
    .res_o      (res_o)
);

// File: tb/tb_dsp_slice.sv
// Directed bench for dsp_slice: one task per scenario, each checking its own
// results. Inputs change on the falling edge; outputs are sampled there or
// 1 ns after a change.
module tb_dsp_slice;
    localparam int OPW = 18;
    localparam int LW  = 52;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [1:0]   cfg_mode;
    logic         cfg_split;
    logic [3:0]   cfg_reg_en;
    logic [71:0]  a_i, b_i;
    logic [3:0]   a_sgn, b_sgn;
    logic [1:0]   pair_sub;
    logic         acc_sub, acc_clr;
    logic [3:0]   grp_ce, grp_clr;
    logic [207:0] res_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    dsp_slice dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_split(cfg_split),
        .cfg_reg_en(cfg_reg_en), .a_i(a_i), .b_i(b_i), .a_sgn(a_sgn),
        .b_sgn(b_sgn), .pair_sub(pair_sub), .acc_sub(acc_sub),
        .acc_clr(acc_clr), .grp_ce(grp_ce), .grp_clr(grp_clr), .res_o(res_o)
    );

    function automatic logic [LW-1:0] lane_of(input int g);
        return res_o[g*LW +: LW];
    endfunction

    // Exact product of one multiplier, extended to lane width.
    function automatic longint fprod(input logic [17:0] a, input logic [17:0] b,
                                     input logic sa, input logic sb);
        longint ax = sa ? longint'($signed(a)) : longint'(a);
        longint bx = sb ? longint'($signed(b)) : longint'(b);
        return ax * bx;
    endfunction

    // Half-width product kept to 18 bits.
    function automatic logic [17:0] hprod(input logic [8:0] a, input logic [8:0] b,
                                         input logic sa, input logic sb);
        int ax = sa ? int'($signed(a)) : int'(a);
        int bx = sb ? int'($signed(b)) : int'(b);
        return 18'(ax * bx);
    endfunction

    task automatic chk(input string req, input logic [LW-1:0] act,
                       input logic [LW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_op(input int i, input logic [17:0] a, input logic [17:0] b);
        a_i[i*OPW +: OPW] = a;
        b_i[i*OPW +: OPW] = b;
    endtask

    function automatic longint pr(input int i);
        return fprod(a_i[i*OPW +: OPW], b_i[i*OPW +: OPW], a_sgn[i], b_sgn[i]);
    endfunction

    task automatic t_reset();
        rst_n = 1'b0; cfg_mode = 2'd0; cfg_split = 1'b0; cfg_reg_en = 4'hF;
        a_sgn = 4'h0; b_sgn = 4'h0; pair_sub = 2'b00; acc_sub = 1'b0;
        acc_clr = 1'b0; grp_ce = 4'hF; grp_clr = 4'h0;
        for (int i = 0; i < 4; i++) set_op(i, 18'h1234 + 18'(i), 18'h0777);
        repeat (3) @(negedge clk);
        rst_n = 1'b1; grp_ce = 4'h0;
        @(negedge clk);
        for (int g = 0; g < 4; g++) chk("R9 reset", lane_of(g), '0);
    endtask

    task automatic t_mul();
        cfg_reg_en = 4'h0; cfg_mode = 2'd0; cfg_split = 1'b0;
        set_op(0, 18'h20000, 18'h20000); set_op(1, 18'h3FFFF, 18'h3FFFF);
        set_op(2, 18'h3FFFF, 18'h00005); set_op(3, 18'h1ABCD, 18'h2F00F);
        a_sgn = 4'b0101; b_sgn = 4'b0011;
        #1;
        for (int g = 0; g < 4; g++) chk("R1 R8", lane_of(g), LW'(pr(g)));
        a_sgn = 4'b1010; b_sgn = 4'b1100;
        #1;
        for (int g = 0; g < 4; g++) chk("R1 mixed sign", lane_of(g), LW'(pr(g)));
    endtask

    task automatic t_split();
        logic [LW-1:0] e;
        cfg_mode = 2'd0; cfg_split = 1'b1; cfg_reg_en = 4'h0;
        set_op(0, {9'h100, 9'h100}, {9'h1FF, 9'h0FF});
        set_op(1, {9'h1FF, 9'h1FF}, {9'h1FF, 9'h1FF});
        set_op(2, {9'h07B, 9'h1C3}, {9'h155, 9'h0AA});
        set_op(3, {9'h001, 9'h180}, {9'h180, 9'h002});
        a_sgn = 4'b0011; b_sgn = 4'b1001;
        #1;
        for (int g = 0; g < 4; g++) begin
            e = {16'h0,
                 hprod(a_i[g*OPW+9 +: 9], b_i[g*OPW+9 +: 9], a_sgn[g], b_sgn[g]),
                 hprod(a_i[g*OPW +: 9], b_i[g*OPW +: 9], a_sgn[g], b_sgn[g])};
            chk("R2 split", lane_of(g), e);
        end
        cfg_split = 1'b0;
    endtask

    task automatic t_mac();
        longint acc;
        @(negedge clk);
        cfg_mode = 2'd1; cfg_reg_en = 4'h0; cfg_split = 1'b1;
        a_sgn = 4'h1; b_sgn = 4'h1;
        set_op(0, 18'h3FF00, 18'h00123); set_op(1, 18'h00111, 18'h00222);
        acc_clr = 1'b1; acc_sub = 1'b1;
        acc = pr(0);
        @(negedge clk);
        chk("R4 load", lane_of(0), LW'(acc));
        for (int g = 1; g < 4; g++) chk("R3 idle lane", lane_of(g), '0);
        acc_clr = 1'b0; acc_sub = 1'b0; set_op(0, 18'h1FFFF, 18'h1FFFF);
        acc = acc + pr(0);
        @(negedge clk);
        chk("R3 add R7", lane_of(0), LW'(acc));
        acc = acc + pr(0);
        @(negedge clk);
        chk("R3 add again", lane_of(0), LW'(acc));
        acc_sub = 1'b1; set_op(0, 18'h20000, 18'h1FFFF);
        acc = acc - pr(0);
        @(negedge clk);
        chk("R3 subtract", lane_of(0), LW'(acc));
        acc_clr = 1'b1; set_op(0, 18'h00007, 18'h3FFFD);
        acc = pr(0);
        @(negedge clk);
        chk("R4 reload", lane_of(0), LW'(acc));
        acc_clr = 1'b0; acc_sub = 1'b0;
        cfg_mode = 2'd0; cfg_split = 1'b0;
        @(negedge clk);
        cfg_mode = 2'd1; set_op(0, 18'h00003, 18'h00005);
        @(negedge clk);
        chk("R4 zero after leave", lane_of(0), LW'(longint'(15)));
        cfg_mode = 2'd0;
        @(negedge clk);
    endtask

    task automatic t_add2();
        longint e0, e1;
        cfg_mode = 2'd2; cfg_reg_en = 4'h0; cfg_split = 1'b1;
        a_sgn = 4'hF; b_sgn = 4'hF;
        set_op(0, 18'h20000, 18'h20000); set_op(1, 18'h20000, 18'h1FFFF);
        set_op(2, 18'h00321, 18'h3FF00); set_op(3, 18'h1F0F0, 18'h00042);
        pair_sub = 2'b01;
        #1;
        e0 = pr(0) - pr(1); e1 = pr(2) + pr(3);
        chk("R5 pair0 sub R7", lane_of(0), LW'(e0));
        chk("R5 pair1 add", lane_of(1), LW'(e1));
        chk("R5 lane2", lane_of(2), '0);
        chk("R5 lane3", lane_of(3), '0);
        pair_sub = 2'b10;
        #1;
        chk("R5 pair0 add", lane_of(0), LW'(pr(0) + pr(1)));
        chk("R5 pair1 sub", lane_of(1), LW'(pr(2) - pr(3)));
    endtask

    task automatic t_add4();
        cfg_mode = 2'd3; cfg_reg_en = 4'h0; cfg_split = 1'b1;
        a_sgn = 4'hF; b_sgn = 4'hF;
        for (int i = 0; i < 4; i++) set_op(i, 18'h20000, 18'h20000);
        pair_sub = 2'b00;
        #1;
        chk("R6 max sum R7", lane_of(0), LW'(pr(0) + pr(1) + pr(2) + pr(3)));
        for (int g = 1; g < 4; g++) chk("R6 idle lane", lane_of(g), '0);
        a_sgn = 4'b0110; set_op(1, 18'h3FFFF, 18'h12345); set_op(3, 18'h00FFF, 18'h3F00F);
        pair_sub = 2'b11;
        #1;
        chk("R6 mixed", lane_of(0), LW'((pr(0) - pr(1)) + (pr(2) - pr(3))));
        cfg_split = 1'b0;
    endtask

    task automatic t_regs();
        longint x1 [4];
        @(negedge clk);
        cfg_mode = 2'd0; cfg_split = 1'b0; pair_sub = 2'b00;
        a_sgn = 4'b1001; b_sgn = 4'b1100; cfg_reg_en = 4'hF; grp_ce = 4'hF;
        for (int i = 0; i < 4; i++) set_op(i, 18'h0F0F0 + 18'(i*997), 18'h3A5A5 - 18'(i*31));
        for (int i = 0; i < 4; i++) x1[i] = pr(i);
        @(negedge clk);
        for (int g = 0; g < 4; g++) chk("R9 load", lane_of(g), LW'(x1[g]));
        grp_ce = 4'b0101;
        for (int i = 0; i < 4; i++) set_op(i, 18'h01111 * 18'(i+1), 18'h00123);
        #1;
        for (int g = 0; g < 4; g++) chk("R9 no edge yet", lane_of(g), LW'(x1[g]));
        @(negedge clk);
        chk("R9 enabled lane0", lane_of(0), LW'(pr(0)));
        chk("R9 held lane1", lane_of(1), LW'(x1[1]));
        chk("R9 enabled lane2", lane_of(2), LW'(pr(2)));
        chk("R9 held lane3", lane_of(3), LW'(x1[3]));
        cfg_reg_en = 4'h0;
        #1;
        for (int g = 0; g < 4; g++) chk("R8 bypass", lane_of(g), LW'(pr(g)));
    endtask

    task automatic t_clr();
        @(negedge clk);
        cfg_reg_en = 4'hF; grp_ce = 4'hF;
        @(negedge clk);
        grp_ce = 4'h0; grp_clr = 4'b0010;
        #1;
        chk("R10 cleared lane1", lane_of(1), '0);
        chk("R10 lane0 kept", lane_of(0), LW'(pr(0)));
        chk("R10 lane2 kept", lane_of(2), LW'(pr(2)));
        chk("R10 lane3 kept", lane_of(3), LW'(pr(3)));
        @(negedge clk);
        grp_clr = 4'b0000;
        @(negedge clk);
        chk("R10 stays clear", lane_of(1), '0);
        chk("R9 lane0 held", lane_of(0), LW'(pr(0)));
        cfg_reg_en = 4'h0;
    endtask

    initial begin
        #4000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_mul();
        t_split();
        t_mac();
        t_add2();
        t_add4();
        t_regs();
        t_clr();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule